// File: doc/BRIEF.md
# BCD Calendar Clock with Update Freeze

This block keeps the time of day and the calendar date in packed BCD, from seconds up to a two-digit century. A private chain of counters advances on each one-second tick. One cycle later the whole set of software-visible copies is refreshed from that chain in a single step, so a read never sees a half-carried value. Software reaches eight time registers and one control register through a 4-bit address, an 8-bit write port with a write strobe, and a registered read port with a read strobe.

A freeze bit in the control register stops the refresh of the visible copies while the private chain keeps counting. The bit has two uses. To read a consistent time, software sets it, reads, and clears it; the copies then catch up at the next tick. To set the time, software sets it, writes new values, and clears it; the written values are then loaded into the chain. A power-fail input blocks every write. A run-in-backup bit decides whether ticks are honoured while the backup-mode input is high.

Register map: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 day of week, 5 month, 6 year, 7 century, 8 control (bit 0 freeze, bit 1 hour24, bit 2 runInBackup). Addresses 9 to 15 read as zero.

Top module: `calClockTop`

## Requirements
- R1: After reset the visible registers read seconds 00, minutes 00, hours 00, day 01, day of week 1, month 01, year 00, century 20, and control 0x06 (freeze clear, 24-hour format, run in backup).
- R2: Each honoured tick advances the chain by one second. The visible copies take the new value one clock after the tick is sampled. A read returns data one clock after the read strobe.
- R3: Seconds and minutes wrap 59 to 00. In 24-hour format hours wrap 23 to 00. The day wraps to 01 after the last day of the month. Month wraps 12 to 01. Year wraps 99 to 00 and increments the century. Day of week (1 = Sunday through 7 = Saturday) steps on each day carry and wraps 7 to 1.
- R4: April, June, September and November have 30 days and February has 28 days. February has 29 days in a leap year: a nonzero year divisible by 4, or year 00 with a century divisible by 4.
- R5: With hour24 = 0, hours run 01 to 12 with bit 7 as the PM flag. 11 becomes 12 with PM toggled. 12 becomes 01 with PM kept. The day carries only on the step from 11 PM (0x91) to 12 AM (0x12).
- R6: While freeze = 1 the visible copies do not change on ticks but the chain keeps counting. If nothing was written during the freeze, clearing it lets the next tick show the fully advanced time.
- R7: Time writes made while freeze = 1 are loaded into the chain when freeze is cleared. A time write made while freeze = 0 changes only the visible copy and is replaced at the next refresh.
- R8: A refresh whose tick was sampled before freeze was set still completes, even when the freeze write lands in the same cycle as the tick.
- R9: Unused bits are not stored and read as 0. The masks are: seconds and minutes 0x7F, hours 0x3F (24-hour) or 0xBF (12-hour), day 0x3F, day of week 0x07, month 0x1F, control 0x07. Addresses 9 to 15 read 0.
- R10: While powerFail = 1, writes to every register, control included, have no effect.
- R11: With backupMode = 1 and runInBackup = 0, ticks are ignored. With backupMode = 0, ticks are honoured whatever runInBackup holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickPps | input | 1 | One-cycle pulse once per second |
| backupMode | input | 1 | High while running from the backup supply |
| powerFail | input | 1 | High while the supply is failing; blocks writes |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |

## Verification
A tick sampled at one edge changes the chain at that edge, and the visible copy changes at the next edge. A read strobe returns data one further edge later. After every tick the bench therefore waits one idle cycle before it issues a read. Each read pushes its expected value into a queue. A monitor pops the queue at the falling edge after the read edge and compares the result, so every result is checked in the exact cycle it is due.

// File: rtl/calPkg.sv
package calPkg;
  parameter int CAL_DW = 8;
  parameter int CAL_AW = 4;
  parameter int CAL_NREG = 8;
  localparam int IDX_W = $clog2(CAL_NREG);

  localparam int IX_SEC = 0;
  localparam int IX_MIN = 1;
  localparam int IX_HR  = 2;
  localparam int IX_DAY = 3;
  localparam int IX_DOW = 4;
  localparam int IX_MON = 5;
  localparam int IX_YR  = 6;
  localparam int IX_CEN = 7;

  localparam logic [CAL_AW-1:0] ADDR_CTRL = CAL_AW'(CAL_NREG);
  localparam int BIT_FRZ = 0;
  localparam int BIT_H24 = 1;
  localparam int BIT_RUN = 2;

  typedef struct packed {
    logic              advance;
    logic              copyUser;
    logic              loadCnt;
    logic              wrUser;
    logic [IDX_W-1:0]  wrIdx;
    logic [CAL_DW-1:0] wrVal;
  } calStrobe_t;

  function automatic logic [7:0] fieldMask(input logic [IDX_W-1:0] idx, input logic hour24);
    case (int'(idx))
      IX_SEC, IX_MIN: fieldMask = 8'h7F;
      IX_HR:          fieldMask = hour24 ? 8'h3F : 8'hBF;
      IX_DAY:         fieldMask = 8'h3F;
      IX_DOW:         fieldMask = 8'h07;
      IX_MON:         fieldMask = 8'h1F;
      default:        fieldMask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] resetVal(input int idx);
    case (idx)
      IX_DAY, IX_DOW, IX_MON: resetVal = 8'h01;
      IX_CEN:                 resetVal = 8'h20;
      default:                resetVal = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] x);
    bcdInc = (x[3:0] >= 4'd9) ? {x[7:4] + 4'd1, 4'd0} : x + 8'd1;
  endfunction

  function automatic logic [7:0] bcd2bin(input logic [7:0] x);
    bcd2bin = {4'd0, x[7:4]} * 8'd10 + {4'd0, x[3:0]};
  endfunction

  function automatic logic [7:0] monthLast(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      monthLast = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: monthLast = 8'h30;
      default:                    monthLast = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import calPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickPps,
  input  logic              backupMode,
  input  logic              powerFail,
  input  logic [CAL_AW-1:0] addr,
  input  logic              wrEn,
  input  logic [CAL_DW-1:0] wrData,
  output calStrobe_t        strb,
  output logic              hour24,
  output logic [CAL_DW-1:0] ctrlVal
);
  logic freeze, runBackup, dirty, updPending;
  logic ctrlWr, timeWr, runOk;

  assign ctrlWr = wrEn && !powerFail && (addr == ADDR_CTRL);
  assign timeWr = wrEn && !powerFail && (addr < CAL_AW'(CAL_NREG));
  assign runOk  = !backupMode || runBackup;

  always_comb begin
    strb.loadCnt  = ctrlWr && freeze && !wrData[BIT_FRZ] && dirty;
    strb.advance  = tickPps && runOk && !strb.loadCnt;
    strb.copyUser = updPending;
    strb.wrUser   = timeWr;
    strb.wrIdx    = addr[IDX_W-1:0];
    strb.wrVal    = wrData & fieldMask(addr[IDX_W-1:0], hour24);
  end

  assign ctrlVal = {{(CAL_DW-3){1'b0}}, runBackup, hour24, freeze};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freeze     <= 1'b0;
      hour24     <= 1'b1;
      runBackup  <= 1'b1;
      dirty      <= 1'b0;
      updPending <= 1'b0;
    end else begin
      // the freeze value seen at the tick decides the refresh
      updPending <= strb.advance && !freeze;
      if (ctrlWr) begin
        freeze    <= wrData[BIT_FRZ];
        hour24    <= wrData[BIT_H24];
        runBackup <= wrData[BIT_RUN];
        if (!wrData[BIT_FRZ]) dirty <= 1'b0;
      end else if (timeWr && freeze) begin
        dirty <= 1'b1;
      end
    end
  end

  a_r10_pf_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |-> (!strb.wrUser && !strb.loadCnt));
  a_r11_stop_in_backup: assert property (@(posedge clk) disable iff (!rstN)
    (backupMode && !runBackup) |-> !strb.advance);
  a_r6_no_refresh_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (tickPps && freeze) |=> !strb.copyUser);
  a_r8_inflight_refresh: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !freeze) |=> strb.copyUser);
endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import calPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strb,
  input  logic              hour24,
  input  logic [CAL_AW-1:0] addr,
  input  logic              rdEn,
  input  logic [CAL_DW-1:0] ctrlVal,
  output logic [CAL_DW-1:0] rdData
);
  logic [CAL_NREG-1:0][CAL_DW-1:0] cnt, usr, nxt;
  logic leap, secWrap, minWrap, hrWrap, dayWrap, monWrap, yrWrap;
  logic [4:0] hrLow;
  logic       pm;
  logic [7:0] hrInc;

  always_comb begin
    nxt     = cnt;
    leap    = (bcd2bin(cnt[IX_YR]) != 8'd0) ? (bcd2bin(cnt[IX_YR]) % 8'd4 == 8'd0)
                                            : (bcd2bin(cnt[IX_CEN]) % 8'd4 == 8'd0);
    hrLow   = cnt[IX_HR][4:0];
    pm      = cnt[IX_HR][7];
    hrInc   = bcdInc({3'b0, hrLow});
    secWrap = cnt[IX_SEC] >= 8'h59;
    minWrap = secWrap && (cnt[IX_MIN] >= 8'h59);
    if (hour24) hrWrap = minWrap && (cnt[IX_HR] >= 8'h23);
    else        hrWrap = minWrap && pm && (hrLow == 5'h11);
    dayWrap = hrWrap && (cnt[IX_DAY] >= monthLast(cnt[IX_MON], leap));
    monWrap = dayWrap && (cnt[IX_MON] >= 8'h12);
    yrWrap  = monWrap && (cnt[IX_YR] >= 8'h99);

    nxt[IX_SEC] = secWrap ? 8'h00 : bcdInc(cnt[IX_SEC]);
    if (secWrap) nxt[IX_MIN] = minWrap ? 8'h00 : bcdInc(cnt[IX_MIN]);
    if (minWrap) begin
      if (hour24)                nxt[IX_HR] = hrWrap ? 8'h00 : bcdInc(cnt[IX_HR]);
      else if (hrLow == 5'h11)   nxt[IX_HR] = {~pm, 2'b00, 5'h12};
      else if (hrLow == 5'h12)   nxt[IX_HR] = {pm, 2'b00, 5'h01};
      else                       nxt[IX_HR] = {pm, 2'b00, hrInc[4:0]};
    end
    if (hrWrap) begin
      nxt[IX_DAY] = dayWrap ? 8'h01 : bcdInc(cnt[IX_DAY]);
      nxt[IX_DOW] = (cnt[IX_DOW] >= 8'd7) ? 8'd1 : cnt[IX_DOW] + 8'd1;
    end
    if (dayWrap) nxt[IX_MON] = monWrap ? 8'h01 : bcdInc(cnt[IX_MON]);
    if (monWrap) nxt[IX_YR]  = yrWrap ? 8'h00 : bcdInc(cnt[IX_YR]);
    if (yrWrap)  nxt[IX_CEN] = (cnt[IX_CEN] >= 8'h99) ? 8'h00 : bcdInc(cnt[IX_CEN]);
  end

  generate
    for (genvar i = 0; i < CAL_NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cnt[i] <= resetVal(i);
          usr[i] <= resetVal(i);
        end else begin
          if (strb.loadCnt)      cnt[i] <= usr[i];
          else if (strb.advance) cnt[i] <= nxt[i];
          if (strb.wrUser && (int'(strb.wrIdx) == i)) usr[i] <= strb.wrVal;
          else if (strb.copyUser)                    usr[i] <= cnt[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (rdEn) begin
      if (addr < CAL_AW'(CAL_NREG)) rdData <= usr[addr[IDX_W-1:0]];
      else if (addr == ADDR_CTRL)   rdData <= ctrlVal;
      else                          rdData <= '0;
    end
  end

  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && cnt[IX_SEC] == 8'h59) |=> (cnt[IX_SEC] == 8'h00));
  a_r5_noon_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !hour24 && cnt[IX_MIN] == 8'h59 && cnt[IX_SEC] == 8'h59
     && cnt[IX_HR] == 8'h11) |=> (cnt[IX_HR] == 8'h92));
  a_r6_copies_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.copyUser && !strb.wrUser) |=> $stable(usr));
  a_r6_chain_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.loadCnt) |=> $stable(cnt));
endmodule

// File: rtl/calClockTop.sv
module calClockTop
  import calPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickPps,
  input  logic              backupMode,
  input  logic              powerFail,
  input  logic [CAL_AW-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [CAL_DW-1:0] wrData,
  output logic [CAL_DW-1:0] rdData
);
  calStrobe_t        strb;
  logic              hour24;
  logic [CAL_DW-1:0] ctrlVal;

  calCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickPps(tickPps), .backupMode(backupMode),
    .powerFail(powerFail), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .strb(strb), .hour24(hour24), .ctrlVal(ctrlVal)
  );

  calDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hour24(hour24), .addr(addr),
    .rdEn(rdEn), .ctrlVal(ctrlVal), .rdData(rdData)
  );
endmodule

// File: tb/test_calClockTop.sv
module test_calClockTop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickPps = 1'b0, backupMode = 1'b0, powerFail = 1'b0;
  logic [3:0] addr = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic rdEnD = 1'b0;

  typedef struct {
    logic [3:0] a;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  calClockTop i_calClockTop (
    .clk(clk), .rstN(rstN), .tickPps(tickPps), .backupMode(backupMode),
    .powerFail(powerFail), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData)
  );

  always @(posedge clk) begin
    rdEnD  <= rdEn;
    cycles <= cycles + 1;
  end

  // monitor: compares each read one edge after its strobe
  always @(negedge clk) begin
    if (rdEnD && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (rdData !== it.exp) begin
        errors++;
        $display("FAIL %s addr %0h: got %02h expected %02h", it.tag, it.a, rdData, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick();
    tickPps = 1'b1;
    @(negedge clk);
    tickPps = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.a = a; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                         input logic [7:0] d, input logic [7:0] w, input logic [7:0] mo,
                         input logic [7:0] y, input logic [7:0] c, input logic [7:0] ctl);
    wr(4'h8, ctl | 8'h01);
    wr(4'h0, s); wr(4'h1, m); wr(4'h2, h); wr(4'h3, d);
    wr(4'h4, w); wr(4'h5, mo); wr(4'h6, y); wr(4'h7, c);
    wr(4'h8, ctl);
  endtask

  initial begin
    idle(); idle();
    rstN = 1'b1;
    idle();

    // R1 reset state
    rd(4'h0, 8'h00, "R1"); rd(4'h1, 8'h00, "R1"); rd(4'h2, 8'h00, "R1");
    rd(4'h3, 8'h01, "R1"); rd(4'h4, 8'h01, "R1"); rd(4'h5, 8'h01, "R1");
    rd(4'h6, 8'h00, "R1"); rd(4'h7, 8'h20, "R1"); rd(4'h8, 8'h06, "R1");

    // R2 one second per tick
    tick(); rd(4'h0, 8'h01, "R2");
    tick(); rd(4'h0, 8'h02, "R2"); rd(4'h1, 8'h00, "R2");

    // R6 freeze for read, chain keeps counting
    wr(4'h8, 8'h07);
    tick(); tick(); tick();
    rd(4'h0, 8'h02, "R6");
    wr(4'h8, 8'h06);
    tick(); rd(4'h0, 8'h06, "R6");

    // R8 tick and freeze write in the same cycle
    tickPps = 1'b1; addr = 4'h8; wrData = 8'h07; wrEn = 1'b1;
    idle();
    tickPps = 1'b0; wrEn = 1'b0;
    idle();
    rd(4'h0, 8'h07, "R8");
    tick(); rd(4'h0, 8'h07, "R8");
    wr(4'h8, 8'h06);
    tick(); rd(4'h0, 8'h09, "R8");

    // R3 full rollover
    setTime(8'h59, 8'h59, 8'h23, 8'h31, 8'h07, 8'h12, 8'h99, 8'h20, 8'h06);
    tick();
    rd(4'h0, 8'h00, "R3"); rd(4'h1, 8'h00, "R3"); rd(4'h2, 8'h00, "R3");
    rd(4'h3, 8'h01, "R3"); rd(4'h4, 8'h01, "R3"); rd(4'h5, 8'h01, "R3");
    rd(4'h6, 8'h00, "R3"); rd(4'h7, 8'h21, "R3");

    // R7 write with freeze clear is not loaded
    wr(4'h0, 8'h30);
    rd(4'h0, 8'h30, "R7");
    tick(); rd(4'h0, 8'h01, "R7");

    // R4 month lengths and leap years
    setTime(8'h59, 8'h59, 8'h23, 8'h28, 8'h03, 8'h02, 8'h24, 8'h20, 8'h06);
    tick(); rd(4'h3, 8'h29, "R4"); rd(4'h5, 8'h02, "R4");
    setTime(8'h59, 8'h59, 8'h23, 8'h28, 8'h03, 8'h02, 8'h23, 8'h20, 8'h06);
    tick(); rd(4'h3, 8'h01, "R4"); rd(4'h5, 8'h03, "R4");
    setTime(8'h59, 8'h59, 8'h23, 8'h28, 8'h03, 8'h02, 8'h00, 8'h20, 8'h06);
    tick(); rd(4'h3, 8'h29, "R4");
    setTime(8'h59, 8'h59, 8'h23, 8'h28, 8'h03, 8'h02, 8'h00, 8'h21, 8'h06);
    tick(); rd(4'h3, 8'h01, "R4"); rd(4'h5, 8'h03, "R4");
    setTime(8'h59, 8'h59, 8'h23, 8'h30, 8'h03, 8'h04, 8'h25, 8'h20, 8'h06);
    tick(); rd(4'h3, 8'h01, "R4"); rd(4'h5, 8'h05, "R4");

    // R5 twelve-hour format
    setTime(8'h59, 8'h59, 8'h11, 8'h05, 8'h02, 8'h03, 8'h24, 8'h20, 8'h04);
    tick(); rd(4'h2, 8'h92, "R5"); rd(4'h3, 8'h05, "R5");
    setTime(8'h59, 8'h59, 8'h92, 8'h05, 8'h02, 8'h03, 8'h24, 8'h20, 8'h04);
    tick(); rd(4'h2, 8'h81, "R5");
    setTime(8'h59, 8'h59, 8'h91, 8'h05, 8'h02, 8'h03, 8'h24, 8'h20, 8'h04);
    tick(); rd(4'h2, 8'h12, "R5"); rd(4'h3, 8'h06, "R5"); rd(4'h4, 8'h03, "R5");

    // R9 unused bits and empty addresses
    wr(4'h8, 8'h07);
    wr(4'h4, 8'hFF); rd(4'h4, 8'h07, "R9");
    wr(4'h2, 8'hFF); rd(4'h2, 8'h3F, "R9");
    wr(4'h8, 8'h05);
    wr(4'h2, 8'hFF); rd(4'h2, 8'hBF, "R9");
    rd(4'hC, 8'h00, "R9");
    wr(4'h8, 8'hFF); rd(4'h8, 8'h07, "R9");
    wr(4'h1, 8'h00);

    // R10 writes ignored during power fail
    powerFail = 1'b1;
    wr(4'h1, 8'h33);
    wr(4'h8, 8'h00);
    rd(4'h1, 8'h00, "R10"); rd(4'h8, 8'h07, "R10");
    powerFail = 1'b0;
    wr(4'h8, 8'h06);

    // R11 run control in backup mode
    setTime(8'h10, 8'h00, 8'h08, 8'h01, 8'h01, 8'h01, 8'h30, 8'h20, 8'h02);
    backupMode = 1'b1;
    tick(); rd(4'h0, 8'h10, "R11");
    backupMode = 1'b0;
    tick(); rd(4'h0, 8'h11, "R11");
    wr(4'h8, 8'h06);
    backupMode = 1'b1;
    tick(); rd(4'h0, 8'h12, "R11");
    backupMode = 1'b0;

    idle(); idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule